// File: doc/BRIEF.md
# Locked Indexed Configuration Register File

This block holds the configuration bytes of a chipset. Software reaches them through two byte-wide I/O ports. A write to the index port at address 22h selects a register. An access to the data port at address 23h then reads or writes the selected register. Every register is also driven onto a wide output bus, so the rest of the chipset sees the current settings without going through the ports.

Configuration writes are guarded by a two-state lock machine. The state LOCK_SHUT is entered at reset. The transition *unlock* moves to LOCK_OPEN when the key C5h is written to index 03h. The transition *relock* moves back to LOCK_SHUT when any other value is written to index 03h. In every other cycle the machine *holds* its state. A key write while already in LOCK_OPEN keeps the state in LOCK_OPEN.

The parameter `EXTENDED` chooses between two register sets. The base set is small. The extended set adds a sparse group of registers, some of which have non-zero reset values. One register forces some of its bits on every write.

Top module: `cfg_regfile`

## Requirements
- R1: A write strobe to address 22h loads the index latch with the write data. The latch resets to 00h. A read of 22h returns the latch. A write to any other address leaves the latch unchanged.
- R2: After reset, the lock machine is in LOCK_SHUT. Every register reads 00h, except the defaults listed in R10.
- R3: Writing C5h to the data port while the index is 03h opens the lock. Writing any other value at index 03h shuts it again. Index 03h itself stores nothing.
- R4: While the lock is shut, a data-port write to any index other than 03h changes no register and no bit of the register output bus.
- R5: A write to index 18h stores (data AND 8Fh) OR 20h. As a result, bit 5 of register 18h reads 1 after any write, and bits 6 and 4 read 0.
- R6: Both variants accept writes at indices 10h to 1Ah, 1Eh and 20h to 27h. Writes to 1Bh to 1Dh, 1Fh and 28h to 2Fh are dropped, and those registers stay 00h.
- R7: Only the extended variant also accepts writes at 30h to 41h, 43h, 45h, 4Ah and 57h. In the base variant these registers stay 00h. In both variants, 42h, 44h and 46h to 49h stay 00h.
- R8: A read of 23h returns the selected register when the index lies in 10h to 4Ah or equals 57h. Any other index, and any read of an address other than 22h or 23h, returns FFh.
- R9: Read data is registered. The valid flag is high exactly in the cycle after a read strobe and low in every other cycle.
- R10: In the extended variant, reset loads 31h=88h, 32h=C0h, 38h=E5h, 40h=E3h, 41h=02h and 45h=80h.
- R11: The register output bus carries register n on bits [8n+7:8n]. An accepted write appears on the bus in the cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_strobe_i | input | 1 | Single-cycle port access strobe |
| io_write_i | input | 1 | 1 = write access, 0 = read access |
| io_addr_i | input | ADDR_W | I/O address of the access |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Registered read data |
| io_rvalid_o | output | 1 | Read data valid, one cycle after a read strobe |
| regs_o | output | 88*8 | All register contents, register n at bits [8n+7:8n] |

## Verification
Some properties are checked by assertions on every cycle:
- the key and relock transitions of the lock machine;
- the freeze of the whole output bus during a shut-lock write;
- the loading of the index latch;
- the forced bits of register 18h;
- the FFh fill for reads of other addresses;
- the one-cycle read valid timing.

Other behaviour can only be shown by the bench's scenarios:
- which sparse indices accept data in each variant;
- the reset defaults;
- the read-back values across the index ranges.

To cover these, the bench runs both variants side by side against one bus.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;

    localparam int unsigned DATA_W    = 8;
    localparam int unsigned REG_COUNT = 88;   // slots 00h..57h

    localparam logic [7:0] LOCK_INDEX  = 8'h03;
    localparam logic [7:0] UNLOCK_KEY  = 8'hC5;
    localparam logic [7:0] FORCE_INDEX = 8'h18;
    localparam logic [7:0] FORCE_KEEP  = 8'h8F;
    localparam logic [7:0] FORCE_SET   = 8'h20;
    localparam logic [7:0] READ_FILL   = 8'hFF;
    localparam logic [7:0] DENSE_LO    = 8'h10;
    localparam logic [7:0] DENSE_HI    = 8'h4A;
    localparam logic [7:0] TOP_SLOT    = 8'h57;

    typedef enum logic {
        LOCK_SHUT,
        LOCK_OPEN
    } lock_state_e;

    typedef enum logic [1:0] {
        PORT_IDLE,
        PORT_INDEX,
        PORT_DATA,
        PORT_FOREIGN
    } port_sel_e;

    // R6: slots writable in every variant
    function automatic bit base_writable(input int unsigned idx);
        return (idx >= 32'h10 && idx <= 32'h1A) || (idx == 32'h1E) ||
               (idx >= 32'h20 && idx <= 32'h27);
    endfunction

    // R7: slots added by the extended variant
    function automatic bit ext_writable(input int unsigned idx);
        return (idx >= 32'h30 && idx <= 32'h41) || (idx == 32'h43) ||
               (idx == 32'h45) || (idx == 32'h4A) || (idx == 32'h57);
    endfunction

    // R2 / R10: reset contents per slot
    function automatic logic [7:0] reset_value(input int unsigned idx, input bit ext);
        logic [7:0] v;
        v = 8'h00;
        if (ext) begin
            case (idx)
                32'h31:  v = 8'h88;
                32'h32:  v = 8'hC0;
                32'h38:  v = 8'hE5;
                32'h40:  v = 8'hE3;
                32'h41:  v = 8'h02;
                32'h45:  v = 8'h80;
                default: v = 8'h00;
            endcase
        end
        return v;
    endfunction

    // R8: indices that the data port reads back
    function automatic bit data_readable(input logic [7:0] idx);
        return ((idx >= DENSE_LO) && (idx <= DENSE_HI)) || (idx == TOP_SLOT);
    endfunction

endpackage

// File: rtl/cfgrf_port_decode.sv
module cfgrf_port_decode
    import cfgrf_pkg::*;
#(
    parameter int unsigned        ADDR_W     = 16,
    parameter logic [ADDR_W-1:0]  INDEX_ADDR = 16'h0022,
    parameter logic [ADDR_W-1:0]  DATA_ADDR  = 16'h0023
) (
    input  logic              strobe_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    output port_sel_e         sel_o,
    output logic              idx_wr_o,
    output logic              data_wr_o,
    output logic              rd_req_o
);

    always_comb begin
        sel_o = PORT_IDLE;
        if (strobe_i) begin
            if (addr_i == INDEX_ADDR) begin
                sel_o = PORT_INDEX;
            end else if (addr_i == DATA_ADDR) begin
                sel_o = PORT_DATA;
            end else begin
                sel_o = PORT_FOREIGN;
            end
        end
    end

    always_comb begin
        idx_wr_o  = (sel_o == PORT_INDEX) && write_i;
        data_wr_o = (sel_o == PORT_DATA) && write_i;
        rd_req_o  = strobe_i && !write_i;
    end

endmodule

// File: rtl/cfgrf_lock_fsm.sv
module cfgrf_lock_fsm
    import cfgrf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       data_wr_i,
    input  logic [7:0] cur_index_i,
    input  logic [7:0] wdata_i,
    output logic       open_o
);

    lock_state_e state_q;
    lock_state_e state_d;
    logic        lock_hit;
    logic        key_ok;

    assign lock_hit = data_wr_i && (cur_index_i == LOCK_INDEX);
    assign key_ok   = (wdata_i == UNLOCK_KEY);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LOCK_SHUT;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: unlock, relock, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOCK_SHUT: begin
                if (lock_hit && key_ok) begin
                    state_d = LOCK_OPEN;
                end
            end
            LOCK_OPEN: begin
                if (lock_hit && !key_ok) begin
                    state_d = LOCK_SHUT;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            LOCK_SHUT: open_o = 1'b0;
            LOCK_OPEN: open_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/cfgrf_reg_bank.sv
module cfgrf_reg_bank
    import cfgrf_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [7:0]                  cur_index_i,
    input  logic [DATA_W-1:0]           wdata_i,
    output logic [REG_COUNT*DATA_W-1:0] regs_o
);

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_slot
        localparam bit          WRITABLE = base_writable(g) || (EXTENDED && ext_writable(g));
        localparam logic [7:0]  INIT     = reset_value(g, EXTENDED);
        localparam bit          FORCED   = (g == int'(FORCE_INDEX));

        if (WRITABLE) begin : g_live
            logic [DATA_W-1:0] slot_q;
            logic [DATA_W-1:0] shaped;
            logic              hit;

            assign hit = wr_en_i && (cur_index_i == 8'(g));

            if (FORCED) begin : g_forced
                assign shaped = (wdata_i & FORCE_KEEP) | FORCE_SET;
            end else begin : g_plain
                assign shaped = wdata_i;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_q <= INIT;
                end else if (hit) begin
                    slot_q <= shaped;
                end
            end

            assign regs_o[g*DATA_W +: DATA_W] = slot_q;
        end else begin : g_tied
            assign regs_o[g*DATA_W +: DATA_W] = INIT;
        end
    end

endmodule

// File: rtl/cfgrf_read_mux.sv
module cfgrf_read_mux
    import cfgrf_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_req_i,
    input  port_sel_e                   sel_i,
    input  logic [7:0]                  cur_index_i,
    input  logic [REG_COUNT*DATA_W-1:0] regs_i,
    output logic [DATA_W-1:0]           rdata_o,
    output logic                        rvalid_o
);

    int unsigned       slot_base;
    logic [DATA_W-1:0] rd_next;

    assign slot_base = int'(cur_index_i) * DATA_W;

    always_comb begin
        unique case (sel_i)
            PORT_INDEX: rd_next = cur_index_i;
            PORT_DATA: begin
                if (data_readable(cur_index_i)) begin
                    rd_next = regs_i[slot_base +: DATA_W];
                end else begin
                    rd_next = READ_FILL;
                end
            end
            default:    rd_next = READ_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_o <= 1'b0;
            rdata_o  <= '0;
        end else begin
            rvalid_o <= rd_req_i;
            if (rd_req_i) begin
                rdata_o <= rd_next;
            end
        end
    end

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfgrf_pkg::*;
#(
    parameter bit                EXTENDED   = 1'b1,
    parameter int unsigned       ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h0022,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h0023
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        io_strobe_i,
    input  logic                        io_write_i,
    input  logic [ADDR_W-1:0]           io_addr_i,
    input  logic [7:0]                  io_wdata_i,
    output logic [7:0]                  io_rdata_o,
    output logic                        io_rvalid_o,
    output logic [REG_COUNT*DATA_W-1:0] regs_o
);

    port_sel_e  port_sel;
    logic       idx_wr;
    logic       data_wr;
    logic       rd_req;
    logic       cfg_open;
    logic [7:0] cur_index;

    cfgrf_port_decode #(
        .ADDR_W     (ADDR_W),
        .INDEX_ADDR (INDEX_ADDR),
        .DATA_ADDR  (DATA_ADDR)
    ) u_decode (
        .strobe_i  (io_strobe_i),
        .write_i   (io_write_i),
        .addr_i    (io_addr_i),
        .sel_o     (port_sel),
        .idx_wr_o  (idx_wr),
        .data_wr_o (data_wr),
        .rd_req_o  (rd_req)
    );

    // index latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_index <= 8'h00;
        end else if (idx_wr) begin
            cur_index <= io_wdata_i;
        end
    end

    cfgrf_lock_fsm u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_wr_i   (data_wr),
        .cur_index_i (cur_index),
        .wdata_i     (io_wdata_i),
        .open_o      (cfg_open)
    );

    cfgrf_reg_bank #(
        .EXTENDED (EXTENDED)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (data_wr && cfg_open),
        .cur_index_i (cur_index),
        .wdata_i     (io_wdata_i),
        .regs_o      (regs_o)
    );

    cfgrf_read_mux u_rmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req_i    (rd_req),
        .sel_i       (port_sel),
        .cur_index_i (cur_index),
        .regs_i      (regs_o),
        .rdata_o     (io_rdata_o),
        .rvalid_o    (io_rvalid_o)
    );

endmodule

// File: rtl/cfgrf_checker.sv
module cfgrf_checker
    import cfgrf_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h0022,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h0023
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        io_strobe_i,
    input logic                        io_write_i,
    input logic [ADDR_W-1:0]           io_addr_i,
    input logic [7:0]                  io_wdata_i,
    input logic [7:0]                  io_rdata_o,
    input logic                        io_rvalid_o,
    input logic                        cfg_open,
    input logic [7:0]                  cur_index,
    input logic [REG_COUNT*DATA_W-1:0] regs
);

    logic       data_wr;
    logic       rd_req;
    logic       foreign_rd;
    logic [7:0] reg18;

    assign data_wr    = io_strobe_i && io_write_i && (io_addr_i == DATA_ADDR);
    assign rd_req     = io_strobe_i && !io_write_i;
    assign foreign_rd = rd_req && (io_addr_i != INDEX_ADDR) && (io_addr_i != DATA_ADDR);
    assign reg18      = regs[int'(FORCE_INDEX)*DATA_W +: DATA_W];

    assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe_i && io_write_i && (io_addr_i == INDEX_ADDR)) |=> (cur_index == $past(io_wdata_i)));

    assert_key_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && (cur_index == LOCK_INDEX) && (io_wdata_i == UNLOCK_KEY)) |=> cfg_open);

    assert_bad_key_shuts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && (cur_index == LOCK_INDEX) && (io_wdata_i != UNLOCK_KEY)) |=> !cfg_open);

    assert_shut_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !cfg_open && (cur_index != LOCK_INDEX)) |=> $stable(regs));

    assert_forced_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg18 != 8'h00) |-> (reg18[5] && !reg18[6] && !reg18[4]));

    assert_foreign_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        foreign_rd |=> (io_rdata_o == READ_FILL));

    assert_rvalid_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> io_rvalid_o);

    assert_rvalid_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !io_rvalid_o);

endmodule

bind cfg_regfile cfgrf_checker #(
    .ADDR_W     (ADDR_W),
    .INDEX_ADDR (INDEX_ADDR),
    .DATA_ADDR  (DATA_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_strobe_i (io_strobe_i),
    .io_write_i  (io_write_i),
    .io_addr_i   (io_addr_i),
    .io_wdata_i  (io_wdata_i),
    .io_rdata_o  (io_rdata_o),
    .io_rvalid_o (io_rvalid_o),
    .cfg_open    (cfg_open),
    .cur_index   (cur_index),
    .regs        (regs_o)
);

// File: tb/tb_cfg_regfile.sv
module tb_cfg_regfile;
    import cfgrf_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int BUS_W      = REG_COUNT * DATA_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             io_strobe_i = 1'b0;
    logic             io_write_i = 1'b0;
    logic [15:0]      io_addr_i = '0;
    logic [7:0]       io_wdata_i = '0;
    logic [7:0]       rdata_x, rdata_b;
    logic             rvalid_x, rvalid_b;
    logic [BUS_W-1:0] regs_x, regs_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] ext_v;
        logic [7:0] base_v;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_regfile #(.EXTENDED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .io_strobe_i(io_strobe_i), .io_write_i(io_write_i),
        .io_addr_i(io_addr_i), .io_wdata_i(io_wdata_i), .io_rdata_o(rdata_x),
        .io_rvalid_o(rvalid_x), .regs_o(regs_x)
    );

    cfg_regfile #(.EXTENDED(1'b0)) dut_base (
        .clk(clk), .rst_n(rst_n), .io_strobe_i(io_strobe_i), .io_write_i(io_write_i),
        .io_addr_i(io_addr_i), .io_wdata_i(io_wdata_i), .io_rdata_o(rdata_b),
        .io_rvalid_o(rvalid_b), .regs_o(regs_b)
    );

    task automatic check8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: pops scoreboard on every read response
    always @(negedge clk) begin
        if (rst_n && (rvalid_x || rvalid_b)) begin
            checks++;
            if (rvalid_x !== rvalid_b || sb_q.size() == 0) begin
                failures++;
                $display("FAIL R9 unexpected read response: actual %b/%b expected none", rvalid_x, rvalid_b);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                check8(it.tag, "ext read", rdata_x, it.ext_v);
                check8(it.tag, "base read", rdata_b, it.base_v);
            end
        end
    end

    task automatic io_write(input logic [15:0] addr, input logic [7:0] data);
        @(negedge clk);
        io_strobe_i = 1'b1; io_write_i = 1'b1; io_addr_i = addr; io_wdata_i = data;
        @(negedge clk);
        io_strobe_i = 1'b0; io_write_i = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] addr, input logic [7:0] ev, input logic [7:0] bv, input string tag);
        exp_t it;
        it.ext_v = ev; it.base_v = bv; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        io_strobe_i = 1'b1; io_write_i = 1'b0; io_addr_i = addr;
        @(negedge clk);
        io_strobe_i = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] val);
        io_write(16'h0022, idx);
        io_write(16'h0023, val);
    endtask

    task automatic rd_reg(input logic [7:0] idx, input logic [7:0] ev, input logic [7:0] bv, input string tag);
        io_write(16'h0022, idx);
        io_read(16'h0023, ev, bv, tag);
    endtask

    task automatic bus_byte(input int idx, input logic [7:0] ev, input logic [7:0] bv, input string tag);
        check8(tag, $sformatf("bus ext %0h", idx), regs_x[idx*8 +: 8], ev);
        check8(tag, $sformatf("bus base %0h", idx), regs_b[idx*8 +: 8], bv);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2 / R10 reset state
        check8("R9", "rvalid in reset", {7'b0, rvalid_x}, 8'h00);
        bus_byte(8'h10, 8'h00, 8'h00, "R2");
        bus_byte(8'h31, 8'h88, 8'h00, "R10");
        bus_byte(8'h32, 8'hC0, 8'h00, "R10");
        bus_byte(8'h38, 8'hE5, 8'h00, "R10");
        bus_byte(8'h40, 8'hE3, 8'h00, "R10");
        bus_byte(8'h41, 8'h02, 8'h00, "R10");
        bus_byte(8'h45, 8'h80, 8'h00, "R10");
        rst_n = 1'b1;

        // R1 index latch reset and R8 low index fill
        io_read(16'h0022, 8'h00, 8'h00, "R1");
        io_read(16'h0023, 8'hFF, 8'hFF, "R8");

        // R4 locked writes dropped
        wr_reg(8'h10, 8'hAA);
        bus_byte(8'h10, 8'h00, 8'h00, "R4");
        wr_reg(8'h45, 8'h11);
        rd_reg(8'h45, 8'h80, 8'h00, "R4");
        rd_reg(8'h10, 8'h00, 8'h00, "R4");

        // R3 unlock then R11 bus update
        wr_reg(8'h03, 8'hC5);
        wr_reg(8'h10, 8'hAA);
        bus_byte(8'h10, 8'hAA, 8'hAA, "R11");
        check8("R9", "rvalid after write", {7'b0, rvalid_x}, 8'h00);
        rd_reg(8'h10, 8'hAA, 8'hAA, "R3");
        io_read(16'h0022, 8'h10, 8'h10, "R1");
        rd_reg(8'h03, 8'hFF, 8'hFF, "R8");

        // R1 writes to other addresses leave the latch
        io_write(16'h0024, 8'h33);
        io_read(16'h0022, 8'h03, 8'h03, "R1");

        // R5 forced bits on index 18h
        wr_reg(8'h18, 8'hFF);
        rd_reg(8'h18, 8'hAF, 8'hAF, "R5");
        wr_reg(8'h18, 8'h00);
        rd_reg(8'h18, 8'h20, 8'h20, "R5");
        wr_reg(8'h18, 8'h50);
        bus_byte(8'h18, 8'h20, 8'h20, "R5");

        // R6 base writable edges and holes
        wr_reg(8'h1A, 8'h11);
        wr_reg(8'h1E, 8'h22);
        wr_reg(8'h20, 8'h33);
        wr_reg(8'h27, 8'h44);
        wr_reg(8'h1B, 8'h55);
        wr_reg(8'h1F, 8'h66);
        wr_reg(8'h28, 8'h77);
        rd_reg(8'h1A, 8'h11, 8'h11, "R6");
        rd_reg(8'h1E, 8'h22, 8'h22, "R6");
        rd_reg(8'h20, 8'h33, 8'h33, "R6");
        rd_reg(8'h27, 8'h44, 8'h44, "R6");
        rd_reg(8'h1B, 8'h00, 8'h00, "R6");
        rd_reg(8'h1F, 8'h00, 8'h00, "R6");
        rd_reg(8'h28, 8'h00, 8'h00, "R6");

        // R7 extended set
        wr_reg(8'h30, 8'h91);
        wr_reg(8'h41, 8'h92);
        wr_reg(8'h43, 8'h93);
        wr_reg(8'h45, 8'h94);
        wr_reg(8'h4A, 8'h95);
        wr_reg(8'h57, 8'h96);
        wr_reg(8'h42, 8'h97);
        wr_reg(8'h44, 8'h98);
        wr_reg(8'h49, 8'h99);
        rd_reg(8'h30, 8'h91, 8'h00, "R7");
        rd_reg(8'h41, 8'h92, 8'h00, "R7");
        rd_reg(8'h43, 8'h93, 8'h00, "R7");
        rd_reg(8'h45, 8'h94, 8'h00, "R7");
        rd_reg(8'h4A, 8'h95, 8'h00, "R7");
        rd_reg(8'h57, 8'h96, 8'h00, "R7");
        rd_reg(8'h42, 8'h00, 8'h00, "R7");
        rd_reg(8'h44, 8'h00, 8'h00, "R7");
        rd_reg(8'h49, 8'h00, 8'h00, "R7");

        // R8 fill cases
        rd_reg(8'h0F, 8'hFF, 8'hFF, "R8");
        rd_reg(8'h4B, 8'hFF, 8'hFF, "R8");
        rd_reg(8'h56, 8'hFF, 8'hFF, "R8");
        rd_reg(8'h58, 8'hFF, 8'hFF, "R8");
        rd_reg(8'hFF, 8'hFF, 8'hFF, "R8");
        io_read(16'h0024, 8'hFF, 8'hFF, "R8");
        io_read(16'h0021, 8'hFF, 8'hFF, "R8");

        // R3 relock, R4 drop, reopen
        wr_reg(8'h03, 8'hC4);
        wr_reg(8'h10, 8'h5A);
        bus_byte(8'h10, 8'hAA, 8'hAA, "R4");
        rd_reg(8'h10, 8'hAA, 8'hAA, "R3");
        wr_reg(8'h03, 8'hC5);
        wr_reg(8'h03, 8'hC5);
        wr_reg(8'h10, 8'h5A);
        rd_reg(8'h10, 8'h5A, 8'h5A, "R3");

        // back-to-back reads, R9
        io_write(16'h0022, 8'h30);
        io_read(16'h0023, 8'h91, 8'h00, "R9");
        io_read(16'h0022, 8'h30, 8'h30, "R9");

        repeat (3) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL R9 missing read responses: actual %0d expected 0", sb_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule